// File: doc/BRIEF.md
# Byte-Access Capture Timer

A 16-bit counter that runs one step per clock while enabled. An edge on a capture source copies the counter value into a capture word. Two compare words and a wrap condition each set an event flag. Each flag raises an interrupt request line only when its mask bit and a global enable input allow it. The capture source is either a pin or a comparator output, chosen by a control bit. The active edge polarity is also selectable. The source passes through a two-stage synchronizer and then an edge comparison, so a capture lands three clock edges after the input changes. A control bit can make the capture word the wrap point of the counter instead of the all-ones value.

Software reaches every 16-bit word through an 8-bit register port. One byte-wide holding register is shared by all four 16-bit words, so each word moves whole. A low-byte read returns the low byte and freezes the high byte into the holder in the same cycle. A high-byte write fills the holder, and the following low-byte write commits both bytes at once. Read data is combinational during a read cycle. A write takes effect at the clock edge that closes its cycle.

Top module: `bytewide_capture_timer`

## Requirements
- R1: After reset every register (counter, capture, both compare words, control, mask, flags and the holding byte) is zero, every address reads zero, and all four interrupt lines are low.
- R2: While control bit 0 (run) is one, the counter advances by one at each clock edge. While it is zero, the counter keeps its value.
- R3: When control bit 2 is one, a rising edge on the selected source captures. When it is zero, a falling edge captures. The source is synchronized through two flops, and the counter value present when the edge is detected is copied into the capture word. The capture flag (flag bit 5) is set at the same edge.
- R4: Control bit 1 picks the capture source: 0 is the pin and 1 is the comparator input. Edges on the source not picked neither capture nor set the capture flag.
- R5: The counter returns to zero at the edge where it equals its wrap point, and the overflow flag (flag bit 0) is set at that edge. The wrap point is the capture word when control bit 3 is one, and 0xFFFF otherwise.
- R6: While running, a counter value equal to compare word A sets flag bit 1. A value equal to compare word B sets flag bit 2.
- R7: Reading a low-byte address returns that word's low byte and loads its high byte into the holding register in the same cycle. Reading a high-byte address returns the holding register, so a capture between the two reads does not tear the value.
- R8: Address map: counter at 0 (low) and 1 (high); capture at 2 and 3; compare A at 4 and 5; compare B at 6 and 7; control at 8; mask at 9; flags at 10. Writing a high-byte address changes only the holding register. Writing a low-byte address commits {holding, written byte} to that word in one cycle.
- R9: The holding register is a single register shared by all words. A high byte written through one word's address is committed by a low-byte write to another word. A high-byte read of any word returns whatever the last low-byte read or high-byte write left there.
- R10: The capture word is read-only: writes to addresses 2 and 3 change neither the capture word nor the holding register.
- R11: The mask register keeps bits 5, 2, 1 and 0. All other bits read as zero.
- R12: An interrupt line is high exactly when its flag bit, its mask bit (same bit position) and the global enable input are all one.
- R13: Writing a one to a flag bit clears it, and a zero leaves it alone. A flag event in the same cycle as a clear of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 (DATA_W) | Write byte |
| bus_rdata | output | 8 (DATA_W) | Read byte, valid while bus_rd is high, zero otherwise |
| cap_pin | input | 1 | Capture pin, asynchronous |
| cmp_in | input | 1 | Comparator output, alternative capture source, asynchronous |
| gie | input | 1 | Global interrupt enable |
| irq_capture | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Overflow / wrap interrupt request |

## Verification
Two pairs of functions can meet in one cycle. The first is a capture event and a software write that clears the capture flag. The bench raises the pin and counts the three synchronizer and edge edges, so that the flag-clear write is on the bus at the exact edge where the capture is detected. It then requires the flag to read back as set, and the capture word to hold the counter. The second pair is a capture and a split 16-bit read: the low byte is read, a capture replaces the word, and the high-byte read must still return the old high byte.

// File: rtl/bct_pkg.sv
package bct_pkg;

    // register port geometry
    localparam int ADDR_W    = 4;
    localparam int WIDE_REGS = 4;

    // index of each 16-bit word; its low byte sits at 2*index, high byte at 2*index+1
    localparam int W_CNT  = 0;
    localparam int W_CAP  = 1;
    localparam int W_CMPA = 2;
    localparam int W_CMPB = 3;

    // byte-wide registers above the word window
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd8;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'd9;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd10;

    // flag / mask bit positions (shared by both registers)
    localparam int EV_OVF  = 0;
    localparam int EV_CMPA = 1;
    localparam int EV_CMPB = 2;
    localparam int EV_CAP  = 5;

    // control bits
    localparam int CTL_RUN    = 0;
    localparam int CTL_ALT    = 1;
    localparam int CTL_RISE   = 2;
    localparam int CTL_TOPCAP = 3;
    localparam int CTL_BITS   = 4;

endpackage

// File: rtl/bct_edge_sync.sv
module bct_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic alt_i,
    input  logic use_alt_i,
    input  logic rise_i,
    output logic evt_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } es_state_t;

    es_state_t st_d, st_q;
    logic      raw;
    logic      level;

    always_comb begin
        raw       = use_alt_i ? alt_i : pin_i;
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        level     = st_q.sync[SYNC_STAGES-1];
        evt_o     = rise_i ? (level & ~st_q.prev) : (~level & st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    edge_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

endmodule

// File: rtl/bct_count_core.sv
module bct_count_core #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              top_cap_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_val_i,
    input  logic              cap_evt_i,
    input  logic [WORD_W-1:0] cmpa_i,
    input  logic [WORD_W-1:0] cmpb_i,
    output logic [WORD_W-1:0] cnt_o,
    output logic [WORD_W-1:0] cap_o,
    output logic              ovf_hit_o,
    output logic              cmpa_hit_o,
    output logic              cmpb_hit_o
);

    typedef struct packed {
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] cap;
    } cc_state_t;

    cc_state_t         st_d, st_q;
    logic [WORD_W-1:0] top;

    always_comb begin
        st_d       = st_q;
        top        = top_cap_i ? st_q.cap : '1;
        ovf_hit_o  = run_i && (st_q.cnt == top);
        cmpa_hit_o = run_i && (st_q.cnt == cmpa_i);
        cmpb_hit_o = run_i && (st_q.cnt == cmpb_i);

        if (load_i)         st_d.cnt = load_val_i;
        else if (ovf_hit_o) st_d.cnt = '0;
        else if (run_i)     st_d.cnt = st_q.cnt + 1'b1;

        if (cap_evt_i)      st_d.cap = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign cap_o = st_q.cap;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && !ovf_hit_o) |=> cnt_o == WORD_W'($past(cnt_o) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_o));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hit_o && !load_i) |=> cnt_o == '0);

    // R3
    cap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_i |=> cap_o == $past(cnt_o));

    // R10
    cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt_i |=> $stable(cap_o));

endmodule

// File: rtl/bct_byte_port.sv
module bct_byte_port
    import bct_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_i,
    input  logic                      wr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [2*DATA_W-1:0]       cnt_i,
    input  logic [2*DATA_W-1:0]       cap_i,
    input  logic [2*DATA_W-1:0]       cmpa_i,
    input  logic [2*DATA_W-1:0]       cmpb_i,
    input  logic [DATA_W-1:0]         ctrl_i,
    input  logic [DATA_W-1:0]         mask_i,
    input  logic [DATA_W-1:0]         flags_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [WIDE_REGS-1:0]      wr_word_o,
    output logic [2*DATA_W-1:0]       word_o,
    output logic                      wr_ctrl_o,
    output logic                      wr_mask_o,
    output logic                      wr_flags_o
);

    localparam int WORD_W = 2 * DATA_W;
    localparam int IDX_W  = $clog2(WIDE_REGS);
    localparam logic [WIDE_REGS-1:0] WRITABLE = ~(WIDE_REGS'(1) << W_CAP);
    localparam logic [ADDR_W-1:0]    WIN_END  = ADDR_W'(2 * WIDE_REGS);
    localparam logic [ADDR_W-1:0]    CAP_HI   = ADDR_W'(2 * W_CAP + 1);

    typedef struct packed {
        logic [DATA_W-1:0] temp;
    } bp_state_t;

    bp_state_t                        st_d, st_q;
    logic [WIDE_REGS-1:0][WORD_W-1:0] words;
    logic [IDX_W-1:0]                 idx;
    logic                             is_wide;
    logic                             is_hi;
    logic [WORD_W-1:0]                sel;

    assign words   = {cmpb_i, cmpa_i, cap_i, cnt_i};
    assign idx     = addr_i[IDX_W:1];
    assign is_wide = addr_i < WIN_END;
    assign is_hi   = addr_i[0];
    assign sel     = words[idx];

    always_comb begin
        st_d = st_q;
        if (rd_i && is_wide && !is_hi)
            st_d.temp = sel[WORD_W-1:DATA_W];
        if (wr_i && is_wide && is_hi && WRITABLE[idx])
            st_d.temp = wdata_i;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (is_wide) begin
                rdata_o = is_hi ? st_q.temp : sel[DATA_W-1:0];
            end else begin
                case (addr_i)
                    A_CTRL:  rdata_o = ctrl_i;
                    A_MASK:  rdata_o = mask_i;
                    A_FLAGS: rdata_o = flags_i;
                    default: rdata_o = '0;
                endcase
            end
        end
    end

    generate
        for (genvar g = 0; g < WIDE_REGS; g++) begin : g_commit
            assign wr_word_o[g] = wr_i && is_wide && !is_hi &&
                                  (idx == IDX_W'(g)) && WRITABLE[g];
        end
    endgenerate

    assign word_o     = {st_q.temp, wdata_i};
    assign wr_ctrl_o  = wr_i && (addr_i == A_CTRL);
    assign wr_mask_o  = wr_i && (addr_i == A_MASK);
    assign wr_flags_o = wr_i && (addr_i == A_FLAGS);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    lo_read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i && is_wide && !is_hi) |=> st_q.temp == $past(sel[WORD_W-1:DATA_W]));

    // R10
    cap_hi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i && addr_i == CAP_HI) |=> $stable(st_q.temp));

endmodule

// File: rtl/bytewide_capture_timer.sv
module bytewide_capture_timer
    import bct_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_pin,
    input  logic              cmp_in,
    input  logic              gie,
    output logic              irq_capture,
    output logic              irq_cmpa,
    output logic              irq_cmpb,
    output logic              irq_ovf
);

    localparam int WORD_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] EV_USED  =
        DATA_W'((1 << EV_OVF) | (1 << EV_CMPA) | (1 << EV_CMPB) | (1 << EV_CAP));
    localparam logic [DATA_W-1:0] CTL_USED = DATA_W'((1 << CTL_BITS) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] flags;
        logic [WORD_W-1:0] cmpa;
        logic [WORD_W-1:0] cmpb;
    } top_state_t;

    top_state_t            st_d, st_q;
    logic                  cap_evt;
    logic [WORD_W-1:0]     cnt, cap;
    logic                  ovf_hit, cmpa_hit, cmpb_hit;
    logic [WIDE_REGS-1:0]  wr_word;
    logic [WORD_W-1:0]     word;
    logic                  wr_ctrl, wr_mask, wr_flags;
    logic [DATA_W-1:0]     ev_set, ev_clr;
    logic                  unused_cap_commit;

    assign unused_cap_commit = wr_word[W_CAP];

    bct_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (cap_pin),
        .alt_i     (cmp_in),
        .use_alt_i (st_q.ctrl[CTL_ALT]),
        .rise_i    (st_q.ctrl[CTL_RISE]),
        .evt_o     (cap_evt)
    );

    bct_count_core #(
        .WORD_W (WORD_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (st_q.ctrl[CTL_RUN]),
        .top_cap_i  (st_q.ctrl[CTL_TOPCAP]),
        .load_i     (wr_word[W_CNT]),
        .load_val_i (word),
        .cap_evt_i  (cap_evt),
        .cmpa_i     (st_q.cmpa),
        .cmpb_i     (st_q.cmpb),
        .cnt_o      (cnt),
        .cap_o      (cap),
        .ovf_hit_o  (ovf_hit),
        .cmpa_hit_o (cmpa_hit),
        .cmpb_hit_o (cmpb_hit)
    );

    bct_byte_port #(
        .DATA_W (DATA_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (bus_rd),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .cnt_i      (cnt),
        .cap_i      (cap),
        .cmpa_i     (st_q.cmpa),
        .cmpb_i     (st_q.cmpb),
        .ctrl_i     (st_q.ctrl),
        .mask_i     (st_q.mask),
        .flags_i    (st_q.flags),
        .rdata_o    (bus_rdata),
        .wr_word_o  (wr_word),
        .word_o     (word),
        .wr_ctrl_o  (wr_ctrl),
        .wr_mask_o  (wr_mask),
        .wr_flags_o (wr_flags)
    );

    always_comb begin
        st_d = st_q;

        ev_set          = '0;
        ev_set[EV_OVF]  = ovf_hit;
        ev_set[EV_CMPA] = cmpa_hit;
        ev_set[EV_CMPB] = cmpb_hit;
        ev_set[EV_CAP]  = cap_evt;
        ev_clr          = wr_flags ? (bus_wdata & EV_USED) : '0;

        st_d.flags = (st_q.flags & ~ev_clr) | ev_set;

        if (wr_ctrl)          st_d.ctrl = bus_wdata & CTL_USED;
        if (wr_mask)          st_d.mask = bus_wdata & EV_USED;
        if (wr_word[W_CMPA])  st_d.cmpa = word;
        if (wr_word[W_CMPB])  st_d.cmpb = word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_capture = gie && st_q.flags[EV_CAP]  && st_q.mask[EV_CAP];
    assign irq_cmpa    = gie && st_q.flags[EV_CMPA] && st_q.mask[EV_CMPA];
    assign irq_cmpb    = gie && st_q.flags[EV_CMPB] && st_q.mask[EV_CMPB];
    assign irq_ovf     = gie && st_q.flags[EV_OVF]  && st_q.mask[EV_OVF];

    // R13
    cap_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> st_q.flags[EV_CAP]);

    // R13
    ovf_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && bus_wdata[EV_OVF] && !ovf_hit) |=> !st_q.flags[EV_OVF]);

    // R12
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_capture || irq_cmpa || irq_cmpb || irq_ovf) |-> gie);

    // R6
    cmpa_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmpa_hit |=> st_q.flags[EV_CMPA]);

endmodule

// File: tb/bytewide_capture_timer_bench.sv
`timescale 1ns/1ps
module bytewide_capture_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0, cmp_in = 1'b0, gie = 1'b0;
    logic       irq_capture, irq_cmpa, irq_cmpb, irq_ovf;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    typedef struct {
        logic [3:0] a;
        logic [7:0] e;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    bytewide_capture_timer u_bytewide_capture_timer (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .cmp_in(cmp_in), .gie(gie),
        .irq_capture(irq_capture), .irq_cmpa(irq_cmpa),
        .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
    );

    // monitor: pops the expected byte for every read cycle
    always @(negedge clk) begin
        #1;
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL scoreboard: read with nothing expected, act=%02h exp=none", bus_rdata);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                n_run++;
                if (bus_rdata !== it.e) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d act=%02h exp=%02h", it.tag, it.a, bus_rdata, it.e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back('{a: a, e: e, tag: tag});
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
        wr(lo + 4'd1, v[15:8]);
        wr(lo, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] lo, input logic [15:0] v, input string tag);
        rd(lo, v[7:0], tag);
        rd(lo + 4'd1, v[15:8], tag);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // run bit high for k+2 counting edges
    task automatic run_for(input logic [7:0] ctl_run, input logic [7:0] ctl_stop, input int k);
        wr(4'd8, ctl_run);
        wait_cyc(k);
        wr(4'd8, ctl_stop);
    endtask

    task automatic chk_irq(input logic [3:0] e, input string tag);
        @(negedge clk); #1;
        n_run++;
        if ({irq_capture, irq_cmpb, irq_cmpa, irq_ovf} !== e) begin
            n_fail++;
            $display("FAIL %s irq act=%b exp=%b", tag,
                     {irq_capture, irq_cmpb, irq_cmpa, irq_ovf}, e);
        end
    endtask

    task automatic finish_run();
        wait (exp_q.size() == 0);
        wait_cyc(2);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 11; a++) rd(4'(a), 8'h00, "R1");
        chk_irq(4'b0000, "R1");

        // R11 mask keeps bits 5,2,1,0 only
        wr(4'd9, 8'hFF);
        rd(4'd9, 8'h27, "R11");
        wr(4'd9, 8'h00);
        rd(4'd9, 8'h00, "R11");

        // R8 split write of compare A
        wr16(4'd4, 16'h0101);
        rd16(4'd4, 16'h0101, "R8");

        // R9 high byte through counter address, committed into compare B
        wr(4'd1, 8'h02);
        wr(4'd6, 8'h00);
        rd16(4'd6, 16'h0200, "R9");
        rd16(4'd0, 16'h0000, "R8");

        // R2 / R6 counting across the byte boundary, compare A hit
        wr16(4'd0, 16'h00FE);
        run_for(8'h01, 8'h00, 3);
        rd16(4'd0, 16'h0103, "R2");
        rd(4'd10, 8'h02, "R6");
        wait_cyc(5);
        rd(4'd0, 8'h03, "R2");

        // R12 gating
        gie = 1'b1;
        wr(4'd9, 8'h02);
        chk_irq(4'b0010, "R12");
        wr(4'd9, 8'h04);
        chk_irq(4'b0000, "R12");
        wr(4'd9, 8'h02);
        gie = 1'b0;
        chk_irq(4'b0000, "R12");
        gie = 1'b1;
        chk_irq(4'b0010, "R12");

        // R13 write-one-to-clear
        wr(4'd10, 8'h00);
        rd(4'd10, 8'h02, "R13");
        wr(4'd10, 8'h02);
        rd(4'd10, 8'h00, "R13");
        chk_irq(4'b0000, "R12");

        // R5 natural wrap at all-ones
        wr16(4'd0, 16'hFFFE);
        run_for(8'h01, 8'h00, 0);
        rd16(4'd0, 16'h0000, "R5");
        rd(4'd10, 8'h01, "R5");
        wr(4'd10, 8'hFF);
        wr(4'd9, 8'h00);

        // R3 falling-edge capture from the pin
        wr16(4'd0, 16'h0777);
        @(negedge clk); cap_pin = 1'b1;
        wait_cyc(4);
        rd(4'd2, 8'h00, "R3");
        rd(4'd10, 8'h00, "R3");
        @(negedge clk); cap_pin = 1'b0;
        wait_cyc(4);
        rd16(4'd2, 16'h0777, "R3");
        rd(4'd10, 8'h20, "R3");

        // R10 capture addresses ignore writes, holder untouched
        wr(4'd1, 8'h11);
        wr(4'd3, 8'h99);
        wr(4'd2, 8'hAA);
        wr(4'd0, 8'h22);
        rd16(4'd0, 16'h1122, "R10");
        rd16(4'd2, 16'h0777, "R10");
        // R9 low read of counter, high read through compare B address
        rd(4'd0, 8'h22, "R9");
        rd(4'd7, 8'h11, "R9");

        // R7 capture between the two halves of a read
        @(negedge clk); cap_pin = 1'b1;
        wait_cyc(4);
        rd(4'd2, 8'h77, "R7");
        @(negedge clk); cap_pin = 1'b0;
        wait_cyc(4);
        rd(4'd3, 8'h07, "R7");
        rd16(4'd2, 16'h1122, "R7");
        wr(4'd10, 8'h20);

        // R4 comparator source selected, pin ignored
        wr16(4'd0, 16'h0333);
        wr(4'd8, 8'h06);
        @(negedge clk); cap_pin = 1'b1;
        wait_cyc(4);
        @(negedge clk); cap_pin = 1'b0;
        wait_cyc(4);
        rd(4'd2, 8'h22, "R4");
        rd(4'd10, 8'h00, "R4");
        @(negedge clk); cmp_in = 1'b1;
        wait_cyc(4);
        rd16(4'd2, 16'h0333, "R4");
        rd(4'd10, 8'h20, "R4");
        @(negedge clk); cmp_in = 1'b0;
        wait_cyc(4);
        wr(4'd10, 8'h20);

        // R13 capture and flag clear in the same cycle: set wins
        wr(4'd8, 8'h04);
        rd(4'd10, 8'h00, "R13");
        @(negedge clk); cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd10; bus_wdata = 8'h20;
        @(negedge clk); bus_wr = 1'b0;
        wait_cyc(2);
        rd(4'd10, 8'h20, "R13");
        rd16(4'd2, 16'h0333, "R3");
        wr(4'd10, 8'h20);
        rd(4'd10, 8'h00, "R13");

        // R5 capture word as wrap point
        wr16(4'd0, 16'h0005);
        @(negedge clk); cap_pin = 1'b0;
        wait_cyc(4);
        @(negedge clk); cap_pin = 1'b1;
        wait_cyc(4);
        rd16(4'd2, 16'h0005, "R5");
        wr(4'd10, 8'hFF);
        wr16(4'd0, 16'h0003);
        run_for(8'h0D, 8'h04, 2);
        rd16(4'd0, 16'h0001, "R5");
        rd(4'd10, 8'h01, "R5");
        wr(4'd9, 8'h01);
        chk_irq(4'b0001, "R12");

        finish_run();
    end

endmodule